// File: doc/BRIEF.md
# Nonvolatile Memory Latency Emulator

This block wraps an on-chip RAM so that it looks, from the client side, like a slow, power-fail-tolerant nonvolatile memory. It is meant for intermittent-computing experiments in which a client state machine issues single-word reads and writes and has to live with long access times and sudden power loss. A request is started with a one-cycle enable. The wrapper then holds busy for a programmable number of cycles before it returns read data or retires the write.

The active-low asynchronous reset `rst_ni` stands for the power-reset net. It clears every piece of control logic, including the latency register, the request hold registers, the error flag and the read-data register. The storage array is not connected to it and keeps its words. A write commits to the array in the cycle it is accepted, so a power reset that arrives later in the access cannot leave a partly written word. After every power reset the wrapper raises a restore-pending flag. While that flag is set it refuses writes and serves reads only, so that the client's first activity has to be its recovery procedure. The client clears the flag with a one-cycle strobe.

Top module: `nvm_emu`

## Requirements
- R1: While `rst_ni` is low and right after it rises: `busy_o`=0, `rdata_valid_o`=0, `proto_err_o`=0, `restore_pending_o`=1, and the access delay register holds `RST_DELAY` (default 8).
- R2: A request is accepted when `req_en_i`=1, `busy_o`=0 and it is not a blocked write (R7). `busy_o` then rises at that clock edge and stays high for exactly D cycles, where D is the delay register's value at acceptance.
- R3: For a read (`req_we_i`=0), `rdata_valid_o` rises at the same edge at which `busy_o` falls. `rdata_o` and `rdata_valid_o` then hold until the next accepted request, which clears `rdata_valid_o`. Writes do not set `rdata_valid_o`.
- R4: An accepted write (`req_we_i`=1) stores `req_wdata_i` at `req_addr_i`. A later read of that address returns the stored word.
- R5: `req_en_i` asserted while `busy_o`=1 is ignored and is not queued. `busy_o` stays low after the current access ends unless a new enable arrives.
- R6: A change of `req_addr_i`, `req_we_i` or `req_wdata_i` at any clock edge where `busy_o`=1, compared with the values captured at acceptance, sets `proto_err_o`. The flag stays set until power reset.
- R7: `restore_pending_o` is set by power reset and cleared by a one-cycle `restore_done_i` strobe. While it is set, write requests are ignored (`busy_o` stays 0) and read requests are accepted.
- R8: Power reset does not change the storage contents. A write that has been accepted keeps its word even when reset arrives before `busy_o` falls.
- R9: `cfg_dly_we_i`=1 loads `cfg_dly_i` into the delay register, and a value of 0 loads 1. A load that happens during an access, or at the acceptance edge itself, takes effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power reset (does not reach storage) |
| cfg_dly_we_i | input | 1 | Load strobe for the access delay register |
| cfg_dly_i | input | CNT_W | New access delay in cycles (0 is taken as 1) |
| req_en_i | input | 1 | Request enable |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| restore_done_i | input | 1 | Strobe that clears the restore-pending flag |
| busy_o | output | 1 | Access in progress |
| rdata_o | output | DATA_W | Read data |
| rdata_valid_o | output | 1 | Read data valid |
| proto_err_o | output | 1 | Sticky flag: request inputs changed while busy |
| restore_pending_o | output | 1 | Restore must run before writes are accepted |

## Verification
The hardest case to reach from the ports is a power reset that lands in the middle of an accepted write. The only proof that the word survived comes later: the client has to strobe restore-done and then read the word back under a new access. The stimulus starts a write, asserts reset a few cycles into the busy window, releases it, and checks that the writes-blocked window and the cleared control state are visible. It then clears the flag and reads the address back. A behavioural model runs alongside and is compared on every cycle against mixed traffic. That traffic includes delay reloads during busy, enables that arrive while busy, and deliberately disturbed request inputs.

// File: rtl/nvm_emu_pkg.sv
package nvm_emu_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } nvm_op_e;
endpackage

// File: rtl/nvm_emu_store.sv
// Storage array; deliberately has no reset input.
module nvm_emu_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvm_emu_timer.sv
module nvm_emu_timer #(
  parameter int CNT_W     = 8,
  parameter int RST_DELAY = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_val_i,
  input  logic             start_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [CNT_W-1:0] dly_o
);
  localparam logic [CNT_W-1:0] One    = CNT_W'(1);
  localparam logic [CNT_W-1:0] DlyRst = (RST_DELAY < 1) ? One : CNT_W'(RST_DELAY);

  logic [CNT_W-1:0] dly_q, cnt_q, cfg_sat;

  assign cfg_sat = (cfg_val_i == '0) ? One : cfg_val_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= DlyRst;
      cnt_q <= '0;
    end else begin
      if (cfg_we_i) dly_q <= cfg_sat;
      if (start_i) cnt_q <= dly_q;
      else if (cnt_q != '0) cnt_q <= cnt_q - One;
    end
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == One);
  assign dly_o  = dly_q;
endmodule

// File: rtl/nvm_emu_guard.sv
// Request hold registers, stability check and restore gate.
module nvm_emu_guard #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              busy_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              restore_done_i,
  output logic              hold_we_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic              proto_err_o,
  output logic              pending_o
);
  import nvm_emu_pkg::*;

  nvm_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q, pend_q, moved;

  assign moved = (req_addr_i != addr_q) || (req_wdata_i != wdata_q) ||
                 (nvm_op_e'(req_we_i) != op_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      pend_q  <= 1'b1;
    end else begin
      if (capture_i) begin
        op_q    <= nvm_op_e'(req_we_i);
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (busy_i && moved) err_q <= 1'b1;
      if (restore_done_i) pend_q <= 1'b0;
    end
  end

  assign hold_we_o   = (op_q == OP_WRITE);
  assign hold_addr_o = addr_q;
  assign proto_err_o = err_q;
  assign pending_o   = pend_q;
endmodule

// File: rtl/nvm_emu.sv
module nvm_emu #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 8,
  parameter int RST_DELAY = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_dly_we_i,
  input  logic [CNT_W-1:0]  cfg_dly_i,
  input  logic              req_en_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              restore_done_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_valid_o,
  output logic              proto_err_o,
  output logic              restore_pending_o
);
  logic              busy, last, accept, pend, hold_we;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] mem_rd, rdata_q;
  logic [CNT_W-1:0]  dly_w;
  logic              rvalid_q;

  assign accept = req_en_i && !busy && !(pend && req_we_i);

  nvm_emu_timer #(.CNT_W(CNT_W), .RST_DELAY(RST_DELAY)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_dly_we_i),
    .cfg_val_i (cfg_dly_i),
    .start_i   (accept),
    .busy_o    (busy),
    .last_o    (last),
    .dly_o     (dly_w)
  );

  nvm_emu_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_guard (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .capture_i      (accept),
    .busy_i         (busy),
    .req_we_i       (req_we_i),
    .req_addr_i     (req_addr_i),
    .req_wdata_i    (req_wdata_i),
    .restore_done_i (restore_done_i),
    .hold_we_o      (hold_we),
    .hold_addr_o    (hold_addr),
    .proto_err_o    (proto_err_o),
    .pending_o      (pend)
  );

  // Write commits at acceptance: atomic against a later power reset.
  nvm_emu_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (accept && req_we_i),
    .waddr_i (req_addr_i),
    .wdata_i (req_wdata_i),
    .raddr_i (hold_addr),
    .rdata_o (mem_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else if (accept) begin
      rvalid_q <= 1'b0;
    end else if (last && !hold_we) begin
      rdata_q  <= mem_rd;
      rvalid_q <= 1'b1;
    end
  end

  assign busy_o            = busy;
  assign rdata_o           = rdata_q;
  assign rdata_valid_o     = rvalid_q;
  assign restore_pending_o = pend;
endmodule

// File: rtl/nvm_emu_chk.sv
module nvm_emu_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_en_i,
  input logic              req_we_i,
  input logic              busy_o,
  input logic              rdata_valid_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              proto_err_o,
  input logic              restore_pending_o,
  input logic [CNT_W-1:0]  dly_w
);
  logic [CNT_W-1:0] run_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      exp_q <= '0;
    end else begin
      run_q <= busy_o ? run_q + CNT_W'(1) : '0;
      if (!busy_o && req_en_i && !(restore_pending_o && req_we_i)) exp_q <= dly_w;
    end
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == exp_q)); // R2
  AST_RVALID_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && !$past(rdata_valid_o)) |-> $fell(busy_o)); // R3
  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_valid_o && $past(rdata_valid_o)) |-> $stable(rdata_o)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proto_err_o |=> proto_err_o); // R6
  AST_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_pending_o && req_en_i && req_we_i && !busy_o) |=> !busy_o); // R7
  AST_PENDING_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_pending_o) |-> 1'b0); // R7
endmodule

bind nvm_emu nvm_emu_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_en_i          (req_en_i),
  .req_we_i          (req_we_i),
  .busy_o            (busy_o),
  .rdata_valid_o     (rdata_valid_o),
  .rdata_o           (rdata_o),
  .proto_err_o       (proto_err_o),
  .restore_pending_o (restore_pending_o),
  .dly_w             (dly_w)
);

// File: tb/nvm_emu_bench.sv
`timescale 1ns/1ps
module nvm_emu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, en = 1'b0, we = 1'b0, done = 1'b0;
  logic [CW-1:0] cfg = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic busy, rv, err, pend;
  logic [DW-1:0] rd;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_emu #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .RST_DELAY(8)) u_nvm_emu (
    .clk_i(clk), .rst_ni(rst_n), .cfg_dly_we_i(cfg_we), .cfg_dly_i(cfg),
    .req_en_i(en), .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wd),
    .restore_done_i(done), .busy_o(busy), .rdata_o(rd), .rdata_valid_o(rv),
    .proto_err_o(err), .restore_pending_o(pend)
  );

  // Behavioural reference model
  int m_cnt, m_dly;
  logic m_pend, m_err, m_rv, h_we;
  logic [DW-1:0] m_rd, h_d;
  logic [AW-1:0] h_a;
  logic [DW-1:0] m_mem [DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_dly = 8; m_pend = 1; m_err = 0; m_rv = 0; m_rd = '0;
      h_we = 0; h_a = '0; h_d = '0;
    end else begin
      if (m_cnt > 0) begin
        if (addr != h_a || we != h_we || wd != h_d) m_err = 1;
        m_cnt--;
        if (m_cnt == 0 && !h_we) begin m_rv = 1; m_rd = m_mem[h_a]; end
      end else if (en && !(m_pend && we)) begin
        m_cnt = m_dly; h_we = we; h_a = addr; h_d = wd; m_rv = 0;
        if (we) m_mem[addr] = wd;
      end
      if (cfg_we) m_dly = (cfg == 0) ? 1 : int'(cfg);
      if (done) m_pend = 0;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 busy", 64'(busy), 64'(m_cnt > 0));
      chk("R3 rdata_valid", 64'(rv), 64'(m_rv));
      if (m_rv && !$isunknown(m_rd)) chk("R4 rdata", 64'(rd), 64'(m_rd));
      chk("R6 proto_err", 64'(err), 64'(m_err));
      chk("R7 restore_pending", 64'(pend), 64'(m_pend));
    end
  end

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk); @(negedge clk); #1 rst_n = 1'b1;
  endtask

  task automatic restore();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic set_dly(input logic [CW-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // One request; returns number of cycles busy was observed high.
  task automatic req(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     output int cyc);
    @(negedge clk); en = 1'b1; we = w; addr = a; wd = d;
    @(negedge clk); en = 1'b0;
    cyc = 0;
    while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
  endtask

  logic [31:0] lf = 32'hACE1_1234;
  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin
    int c;
    // R1: reset state
    @(negedge clk);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 rdata_valid", 64'(rv), 0);
    chk("R1 proto_err", 64'(err), 0);
    chk("R1 restore_pending", 64'(pend), 1);
    @(negedge clk); #1 rst_n = 1'b1;
    // R7: write ignored while pending, read accepted
    req(1'b1, 6'd1, 16'h1111, c);
    chk("R7 write ignored busy cycles", 64'(c), 0);
    req(1'b0, 6'd1, 16'h0, c);
    chk("R7 read accepted while pending", 64'(c), 8);
    restore();
    chk("R7 pending cleared", 64'(pend), 0);
    // fill storage
    for (int i = 0; i < DEPTH; i++) req(1'b1, AW'(i), DW'(i * 16'h0101 + 16'h0033), c);
    // R2: default delay 8
    req(1'b1, 6'd3, 16'hBEEF, c);
    chk("R2 default delay", 64'(c), 8);
    // R3/R4
    req(1'b0, 6'd3, 16'h0, c);
    chk("R3 valid at fall", 64'(rv), 1);
    chk("R4 read back", 64'(rd), 16'hBEEF);
    repeat (3) @(negedge clk);
    chk("R3 data held", 64'(rd), 16'hBEEF);
    // R5: enable while busy not queued
    @(negedge clk); en = 1'b1; we = 1'b0; addr = 6'd3; wd = '0;
    @(negedge clk); en = 1'b0;
    @(negedge clk); @(negedge clk); en = 1'b1;
    @(negedge clk); en = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("R5 no queued request", 64'(busy), 0);
    // R9: zero loads one, then 3, load during busy
    set_dly('0);
    req(1'b0, 6'd4, 16'h0, c);
    chk("R9 zero delay clamps to 1", 64'(c), 1);
    set_dly(8'd3);
    @(negedge clk); en = 1'b1; we = 1'b0; addr = 6'd5;
    @(negedge clk); en = 1'b0; cfg_we = 1'b1; cfg = 8'd5;
    @(negedge clk); cfg_we = 1'b0;
    while (busy) @(negedge clk);
    req(1'b0, 6'd5, 16'h0, c);
    chk("R9 reload applies to next request", 64'(c), 5);
    // R8: reset mid-write, word survives
    set_dly(8'd8);
    @(negedge clk); en = 1'b1; we = 1'b1; addr = 6'd9; wd = 16'h5A5A;
    @(negedge clk); en = 1'b0;
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R8 control cleared by reset", 64'(busy), 0);
    chk("R1 pending after reset", 64'(pend), 1);
    #1 rst_n = 1'b1;
    restore();
    req(1'b0, 6'd9, 16'h0, c);
    chk("R8 write survived reset", 64'(rd), 16'h5A5A);
    req(1'b0, 6'd3, 16'h0, c);
    chk("R8 storage kept", 64'(rd), 16'hBEEF);
    // R6: disturbed address during busy
    @(negedge clk); en = 1'b1; we = 1'b0; addr = 6'd7;
    @(negedge clk); en = 1'b0;
    @(negedge clk); addr = 6'd8;
    @(negedge clk);
    chk("R6 error set", 64'(err), 1);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R6 error sticky", 64'(err), 1);
    do_reset();
    chk("R6 error cleared by reset", 64'(err), 0);
    restore();
    // mixed traffic compared by the model
    for (int k = 0; k < 400; k++) begin
      lf = step(lf);
      if (lf[3:0] == 4'h0) set_dly(CW'(lf[10:8]));
      @(negedge clk); en = 1'b1; we = lf[4]; addr = AW'(lf[17:12]); wd = lf[31:16];
      @(negedge clk); en = lf[5];
      @(negedge clk); en = 1'b0;
      if (lf[6] && lf[7] && lf[8]) wd = ~wd;
      while (busy) @(negedge clk);
      if (lf[11:9] == 3'b111) begin do_reset(); restore(); end
    end
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule